// File: doc/BRIEF.md
# Partitioned Saturating SIMD Adder with Q15 Multiply-Accumulate

This block is a 64-bit add/subtract datapath that can be split at run time into independent lanes of 8, 16 or 32 bits, or used as one 64-bit lane. No carry crosses a lane boundary. Each lane either wraps modulo its width or saturates, in signed or unsigned form. When a lane saturates, its result is clamped to the representable limit that lies nearest the true result.

The same datapath also offers a Q15 fixed-point multiply-accumulate on the four 16-bit lanes. Each lane keeps a private 40-bit accumulator. The product of two Q15 values is added into that accumulator, or loaded into it. The new accumulator value is then narrowed back to a 16-bit Q15 result, using either truncation or round-half-up, and saturated.

The result is registered, so it appears one cycle after the inputs. A sticky flag per lane records any saturation. Only an explicit clear input resets these flags.

Top module: `simd_sat_alu`

## Requirements
- R1: After reset, `result`, `ovf_flags` and all four accumulators are zero.
- R2: `lane_mode` selects the lane width: 0 gives eight 8-bit lanes, 1 gives four 16-bit lanes, 2 gives two 32-bit lanes and 3 gives one 64-bit lane. Lane k occupies bits [k*W +: W]. No carry or borrow passes from one lane into the next.
- R3: `op` 0 adds and `op` 1 subtracts (`op_a` minus `op_b`). With `sat_en` low, each lane's result is the true result modulo 2^W, and `ovf_flags` does not change.
- R4: With `sat_en` high and `is_signed` high, an out-of-range lane result becomes 2^(W-1)-1 if the true result is positive, or -2^(W-1) if it is negative (0x7FFF or 0x8000 for 16-bit lanes).
- R5: With `sat_en` high and `is_signed` low, a lane result below zero becomes 0 and a lane result above 2^W-1 becomes all ones.
- R6: `result` shows the outcome of the inputs that were present at the previous rising clock edge.
- R7: `op` 2 adds the signed product a×b into each 16-bit lane's 40-bit accumulator, wrapping at 40 bits. `op` 3 loads the product into the accumulator instead. Both ignore `lane_mode`, `sat_en` and `is_signed`.
- R8: After a multiply-accumulate, lane k of `result` is the new accumulator shifted arithmetically right by 15. With `round_mode` 1, 2^14 is added to the accumulator before the shift; with `round_mode` 0, nothing is added. The shifted value is then saturated to the range 0x8000 to 0x7FFF.
- R9: `ovf_flags[k]` is set in the cycle after lane k saturates, for either an add/subtract lane or a multiply-accumulate lane. It stays set until `clr_flags` is high. When `clr_flags` is high, all flags are zero in the next cycle, and the clear takes priority over a new saturation in that cycle.
- R10: Add and subtract operations leave the accumulators unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lane_mode | input | 2 | Lane width select (0:8, 1:16, 2:32, 3:64) |
| op | input | 2 | 0 add, 1 subtract, 2 multiply-accumulate, 3 multiply-load |
| sat_en | input | 1 | Saturating add/subtract when high |
| is_signed | input | 1 | Signed lanes for add/subtract when high |
| round_mode | input | 1 | Accumulator narrowing: 0 truncate, 1 round half up |
| clr_flags | input | 1 | Clears all sticky saturation flags |
| op_a | input | 64 | First operand |
| op_b | input | 64 | Second operand |
| result | output | 64 | Registered lane results |
| ovf_flags | output | 8 | Sticky per-lane saturation flags |

## Verification
The properties assume that `op`, `lane_mode` and the mode bits are held valid for the whole cycle and are sampled only on the rising edge. They also assume that `clr_flags` is the only way the flags fall. The bench changes every input at the falling edge, so each set of inputs is stable across the following rising edge.

Directed sequences drive lanes to both saturation limits, chains of multiply-accumulates that overflow the Q15 range, and products that sit exactly on the rounding boundary. A long random phase then mixes every op code, lane width, rounding mode and clear pattern.

// File: rtl/simd_pkg.sv
package simd_pkg;
    localparam int DATA_W   = 64;
    localparam int LANE_MIN = 8;
    localparam int N_FLAG   = DATA_W / LANE_MIN;
    localparam int N_WIDTH  = 4;
    localparam int MAC_W    = 16;
    localparam int N_MAC    = DATA_W / MAC_W;
    localparam int ACC_W    = 40;
    localparam int FRAC     = MAC_W - 1;

    typedef enum logic [1:0] {
        OP_ADD  = 2'd0,
        OP_SUB  = 2'd1,
        OP_MAC  = 2'd2,
        OP_MLD  = 2'd3
    } op_e;

    typedef struct packed {
        logic [DATA_W-1:0]      result;
        logic [N_FLAG-1:0]      flags;
        logic [N_MAC*ACC_W-1:0] acc;
    } state_t;
endpackage

// File: rtl/simd_addsub_lane.sv
module simd_addsub_lane #(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         sub_i,
    input  logic         sat_en_i,
    input  logic         signed_i,
    output logic [W-1:0] y_o,
    output logic         sat_o
);
    logic [W+1:0] ext_a, ext_b, sum;
    logic         too_low, too_high;

    always_comb begin
        ext_a = signed_i ? {{2{a_i[W-1]}}, a_i} : {2'b00, a_i};
        ext_b = signed_i ? {{2{b_i[W-1]}}, b_i} : {2'b00, b_i};
        sum   = sub_i ? (ext_a - ext_b) : (ext_a + ext_b);
        if (signed_i) begin
            too_low  = sum[W+1] & ~sum[W-1];
            too_high = ~sum[W+1] & sum[W-1];
        end else begin
            too_low  = sum[W+1];
            too_high = ~sum[W+1] & sum[W];
        end
        sat_o = sat_en_i & (too_low | too_high);
        if (!sat_o) begin
            y_o = sum[W-1:0];
        end else if (signed_i) begin
            y_o = too_low ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}};
        end else begin
            y_o = too_low ? '0 : '1;
        end
    end
endmodule

// File: rtl/simd_mac_lane.sv
module simd_mac_lane
    import simd_pkg::*;
(
    input  logic [MAC_W-1:0] a_i,
    input  logic [MAC_W-1:0] b_i,
    input  logic [ACC_W-1:0] acc_i,
    input  logic             load_i,
    input  logic             rnd_i,
    output logic [ACC_W-1:0] acc_o,
    output logic [MAC_W-1:0] y_o,
    output logic             sat_o
);
    localparam int PROD_W = 2 * MAC_W;
    localparam int HI_W   = ACC_W + 1 - (MAC_W - 1);

    logic signed [PROD_W-1:0] prod;
    logic        [ACC_W-1:0]  base;
    logic        [ACC_W:0]    half, biased, shifted;
    logic        [HI_W-1:0]   top_bits;

    always_comb begin
        prod    = $signed(a_i) * $signed(b_i);
        base    = load_i ? '0 : acc_i;
        acc_o   = base + {{(ACC_W-PROD_W){prod[PROD_W-1]}}, prod};
        half    = rnd_i ? {{(ACC_W+1-FRAC){1'b0}}, 1'b1, {(FRAC-1){1'b0}}} : '0;
        biased  = {acc_o[ACC_W-1], acc_o} + half;
        shifted = $unsigned($signed(biased) >>> FRAC);
        top_bits = shifted[ACC_W:MAC_W-1];
        sat_o   = ~((&top_bits) | ~(|top_bits));
        if (sat_o) begin
            y_o = shifted[ACC_W] ? {1'b1, {(MAC_W-1){1'b0}}} : {1'b0, {(MAC_W-1){1'b1}}};
        end else begin
            y_o = shifted[MAC_W-1:0];
        end
    end
endmodule

// File: rtl/simd_sat_alu.sv
module simd_sat_alu
    import simd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        lane_mode,
    input  logic [1:0]        op,
    input  logic              sat_en,
    input  logic              is_signed,
    input  logic              round_mode,
    input  logic              clr_flags,
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    output logic [DATA_W-1:0] result,
    output logic [N_FLAG-1:0] ovf_flags
);
    state_t state_d, state_q;

    logic [N_WIDTH-1:0][DATA_W-1:0] sum_w;
    logic [N_WIDTH-1:0][N_FLAG-1:0] sat_w;
    logic [N_MAC-1:0][ACC_W-1:0]    mac_acc;
    logic [DATA_W-1:0]              mac_y;
    logic [N_MAC-1:0]               mac_sat;
    logic [N_FLAG-1:0]              new_sat;
    logic [N_MAC*ACC_W-1:0]         acc_flat;

    // one bank of lane adders per lane width
    for (genvar gw = 0; gw < N_WIDTH; gw++) begin : g_width
        localparam int W  = LANE_MIN << gw;
        localparam int NL = DATA_W / W;
        for (genvar gl = 0; gl < NL; gl++) begin : g_lane
            simd_addsub_lane #(.W(W)) u_lane (
                .a_i      (op_a[gl*W +: W]),
                .b_i      (op_b[gl*W +: W]),
                .sub_i    (op == OP_SUB),
                .sat_en_i (sat_en),
                .signed_i (is_signed),
                .y_o      (sum_w[gw][gl*W +: W]),
                .sat_o    (sat_w[gw][gl])
            );
        end
        for (genvar gu = NL; gu < N_FLAG; gu++) begin : g_unused
            assign sat_w[gw][gu] = 1'b0;
        end
    end

    for (genvar gm = 0; gm < N_MAC; gm++) begin : g_mac
        simd_mac_lane u_mac (
            .a_i    (op_a[gm*MAC_W +: MAC_W]),
            .b_i    (op_b[gm*MAC_W +: MAC_W]),
            .acc_i  (state_q.acc[gm*ACC_W +: ACC_W]),
            .load_i (op == OP_MLD),
            .rnd_i  (round_mode),
            .acc_o  (mac_acc[gm]),
            .y_o    (mac_y[gm*MAC_W +: MAC_W]),
            .sat_o  (mac_sat[gm])
        );
    end

    always_comb begin
        state_d = state_q;
        new_sat = '0;
        unique case (op)
            OP_MAC, OP_MLD: begin
                state_d.result = mac_y;
                state_d.acc    = mac_acc;
                new_sat        = N_FLAG'(mac_sat);
            end
            default: begin
                state_d.result = sum_w[lane_mode];
                new_sat        = sat_w[lane_mode];
            end
        endcase
        state_d.flags = clr_flags ? '0 : (state_q.flags | new_sat);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign result    = state_q.result;
    assign ovf_flags = state_q.flags;
    assign acc_flat  = state_q.acc;
endmodule

// File: rtl/simd_sat_alu_sva.sv
module simd_sat_alu_sva
    import simd_pkg::*;
(
    input logic                   clk,
    input logic                   rst_n,
    input logic [1:0]             lane_mode,
    input logic [1:0]             op,
    input logic                   sat_en,
    input logic                   is_signed,
    input logic                   clr_flags,
    input logic [DATA_W-1:0]      op_a,
    input logic [DATA_W-1:0]      op_b,
    input logic [DATA_W-1:0]      result,
    input logic [N_FLAG-1:0]      ovf_flags,
    input logic [N_MAC*ACC_W-1:0] acc_flat
);
    assert_flags_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_flags |=> ((ovf_flags & $past(ovf_flags)) == $past(ovf_flags)));

    assert_flags_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clr_flags |=> (ovf_flags == '0));

    assert_wrap_no_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!sat_en && !op[1] && !clr_flags) |=> $stable(ovf_flags));

    assert_acc_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !op[1] |=> $stable(acc_flat));

    assert_wide_positive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 2'd0 && sat_en && is_signed && lane_mode == 2'd3
         && !op_a[DATA_W-1] && !op_b[DATA_W-1]) |=> !result[DATA_W-1]);
endmodule

bind simd_sat_alu simd_sat_alu_sva u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .lane_mode (lane_mode),
    .op        (op),
    .sat_en    (sat_en),
    .is_signed (is_signed),
    .clr_flags (clr_flags),
    .op_a      (op_a),
    .op_b      (op_b),
    .result    (result),
    .ovf_flags (ovf_flags),
    .acc_flat  (acc_flat)
);

// File: tb/simd_sat_alu_tb.sv
`timescale 1ns/1ps
module simd_sat_alu_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  lane_mode = '0, op = '0;
    logic        sat_en = 1'b0, is_signed = 1'b0, round_mode = 1'b0, clr_flags = 1'b0;
    logic [63:0] op_a = '0, op_b = '0;
    logic [63:0] result;
    logic [7:0]  ovf_flags;

    int          checks = 0;
    int          errors = 0;
    logic [63:0] exp_res;
    logic [7:0]  exp_flags = '0;
    logic [7:0]  sat_bits;
    longint      acc_m [4] = '{0, 0, 0, 0};

    always #4 clk = ~clk;

    simd_sat_alu u_dut (
        .clk(clk), .rst_n(rst_n), .lane_mode(lane_mode), .op(op),
        .sat_en(sat_en), .is_signed(is_signed), .round_mode(round_mode),
        .clr_flags(clr_flags), .op_a(op_a), .op_b(op_b),
        .result(result), .ovf_flags(ovf_flags)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_addsub(input logic [63:0] a, input logic [63:0] b, input int w,
                                input bit sub, input bit sgn, input bit sat);
        logic [63:0] mask;
        mask = (w == 64) ? '1 : ((64'd1 << w) - 1);
        exp_res  = '0;
        sat_bits = '0;
        for (int l = 0; l < 64 / w; l++) begin
            logic [63:0]        la, lb, piece;
            logic signed [67:0] ea, eb, s, mx, mn, r;
            la = (a >> (l * w)) & mask;
            lb = (b >> (l * w)) & mask;
            ea = $signed({4'b0, la});
            eb = $signed({4'b0, lb});
            if (sgn && la[w-1]) ea = ea - (68'sd1 <<< w);
            if (sgn && lb[w-1]) eb = eb - (68'sd1 <<< w);
            s  = sub ? (ea - eb) : (ea + eb);
            mx = sgn ? ((68'sd1 <<< (w - 1)) - 1) : ((68'sd1 <<< w) - 1);
            mn = sgn ? -(68'sd1 <<< (w - 1)) : 68'sd0;
            r  = s;
            if (sat && s > mx) begin r = mx; sat_bits[l] = 1'b1; end
            if (sat && s < mn) begin r = mn; sat_bits[l] = 1'b1; end
            piece   = r[63:0] & mask;
            exp_res = exp_res | (piece << (l * w));
        end
    endtask

    task automatic model_mac(input logic [63:0] a, input logic [63:0] b, input bit load, input bit rnd);
        exp_res  = '0;
        sat_bits = '0;
        for (int l = 0; l < 4; l++) begin
            longint x, y, v, q;
            x = longint'($signed(a[l*16 +: 16]));
            y = longint'($signed(b[l*16 +: 16]));
            acc_m[l] = (load ? 0 : acc_m[l]) + x * y;
            acc_m[l] = (acc_m[l] <<< 24) >>> 24;
            v = acc_m[l] + (rnd ? 16384 : 0);
            q = v >>> 15;
            if (q > 32767)  begin q = 32767;  sat_bits[l] = 1'b1; end
            if (q < -32768) begin q = -32768; sat_bits[l] = 1'b1; end
            exp_res[l*16 +: 16] = q[15:0];
        end
    endtask

    // called right after a falling edge; checks at the next falling edge
    task automatic drive(input logic [1:0] o, input logic [1:0] lm, input bit s, input bit sg,
                         input bit rn, input bit cl, input logic [63:0] a, input logic [63:0] b,
                         input string tag);
        op = o; lane_mode = lm; sat_en = s; is_signed = sg; round_mode = rn;
        clr_flags = cl; op_a = a; op_b = b;
        if (o[1]) model_mac(a, b, o == 2'd3, rn);
        else      model_addsub(a, b, 8 << lm, o == 2'd1, sg, s);
        exp_flags = cl ? 8'h00 : (exp_flags | sat_bits);
        @(negedge clk);
        chk(tag, result, exp_res);
        chk("R9 flags", {56'd0, ovf_flags}, {56'd0, exp_flags});
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 result", result, 64'd0);
        chk("R1 flags", {56'd0, ovf_flags}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 accumulators zero: accumulate a zero product
        drive(2, 0, 0, 0, 0, 0, 64'd0, 64'd0, "R1 acc");
        // R2 carries cut at byte lanes
        drive(0, 0, 0, 0, 0, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0101_0101_0101_0101, "R2 8-bit");
        drive(0, 1, 0, 0, 0, 0, 64'h0001_FFFF_7FFF_FFFF, 64'h0001_0001_0001_0001, "R2 16-bit");
        // R3 wrap, 32-bit lanes, subtract
        drive(1, 2, 0, 1, 0, 0, 64'h0000_0000_8000_0000, 64'h0000_0001_0000_0001, "R3 wrap sub");
        // R4 signed saturation 16-bit both directions
        drive(0, 1, 1, 1, 0, 0, 64'h7FFF_8000_1234_7FF0, 64'h0001_FFFF_0001_0100, "R4 sat16 add");
        drive(1, 1, 1, 1, 0, 0, 64'h8000_7FFF_0000_0005, 64'h0001_FFFF_0001_0002, "R4 sat16 sub");
        drive(0, 3, 1, 1, 0, 1, 64'h7FFF_FFFF_FFFF_FFF0, 64'h0000_0000_0000_0100, "R4 sat64");
        drive(0, 0, 1, 1, 0, 0, 64'h8080_7F7F_0102_0304, 64'h8080_0101_0102_0304, "R4 sat8");
        // R5 unsigned saturation
        drive(0, 0, 1, 0, 0, 1, 64'hF0F0_F0F0_0000_0001, 64'h2020_0101_0000_0001, "R5 sat8 add");
        drive(1, 2, 1, 0, 0, 0, 64'h0000_0010_FFFF_FFFF, 64'h0000_0020_0000_0001, "R5 sat32 sub");
        drive(0, 1, 0, 0, 0, 0, 64'h0, 64'h0, "R9 hold");
        drive(0, 1, 1, 1, 0, 1, 64'h7FFF_0000_0000_0000, 64'h0001_0000_0000_0000, "R9 clear wins");
        // R7 / R8 multiply-accumulate
        drive(3, 0, 0, 0, 0, 0, 64'h4000_4000_7FFF_8000, 64'h4000_C000_7FFF_8000, "R7 load");
        drive(2, 3, 1, 0, 0, 0, 64'h4000_4000_7FFF_8000, 64'h4000_C000_7FFF_8000, "R7 accumulate");
        drive(2, 1, 0, 1, 0, 0, 64'h4000_4000_7FFF_8000, 64'h4000_C000_7FFF_8000, "R8 saturate");
        drive(3, 0, 0, 0, 0, 1, 64'h0001_0001_0003_FFFF, 64'h4000_C000_4000_C000, "R8 trunc");
        drive(3, 0, 0, 0, 1, 0, 64'h0001_0001_0003_FFFF, 64'h4000_C000_4000_C000, "R8 round");
        // R10 add leaves accumulators untouched
        drive(0, 1, 0, 0, 0, 0, 64'h1111_2222_3333_4444, 64'h5555_6666_7777_8888, "R10 add");
        drive(2, 0, 0, 0, 1, 0, 64'h0001_0001_0001_0001, 64'h0000_0000_0000_0000, "R10 acc kept");
        // R6 back-to-back random stream
        for (int i = 0; i < 600; i++) begin
            logic [1:0] ro;
            bit         rs, rg;
            string      tg;
            ro = 2'($urandom_range(0, 3));
            rs = 1'($urandom_range(0, 1));
            rg = 1'($urandom_range(0, 1));
            tg = ro[1] ? "R7 random mac" : (!rs ? "R3 random wrap" : (rg ? "R4 random sat" : "R5 random sat"));
            drive(ro, 2'($urandom_range(0, 3)), rs, rg, 1'($urandom_range(0, 1)),
                  ($urandom_range(0, 15) == 0), {$urandom, $urandom}, {$urandom, $urandom},
                  (i % 2 == 0) ? "R6 latency" : tg);
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule